// File: doc/BRIEF.md
# Slot Intercept Substitution Controller

This block governs per-channel-pair sample flow on a twelve-slot serial frame shared between an audio codec path and an external DSP. It sees the frame as a stream of slot-aligned 16-bit words, each tagged with its slot number. By default the DSP only listens, and nothing it sends reaches the codec path. A pair is handed to the DSP only when three conditions hold: its intercept enable is set, the DSP marks its data valid in the frame's control slot, and the controller asked that pair for data in the frame before.

Each frame, the controller builds a request bit for every pair from that pair's sample-rate tick. The request bits go out in the outgoing status word. A pair that runs at the full frame rate always requests and is always treated as valid. When a substitution is accepted, the right and left words of the pair are delivered together with a one-cycle strobe, so the downstream path can swap them in place of its own samples.

Top module: `slot_intercept`

## Requirements
- R1: After reset, all substitution strobes are low, the status word is zero and the substituted data outputs are zero.
- R2: At each slot 0 the request bit of a pair is set if that pair's rate tick was high on any cycle since the previous slot 0, including the slot 0 cycle itself, and cleared otherwise. The bits appear in the status word at these positions: SS capture bit 14, SS playback bit 13, I2S port 1 bit 11, I2S port 0 bit 10, FM bit 9. All other bits are 0.
- R3: The status word changes only on the cycle after a slot 0 word and holds for the rest of the frame.
- R4: A pair whose full-rate input is high requests in every frame, and its valid flag is treated as 1.
- R5: A pair is substituted in a frame only if its intercept enable and DSP valid flag are both high when slot 0 arrives, and its request bit was set in the previous frame. Without the full-rate case, a missing request, a low valid flag or a low enable blocks substitution.
- R6: Pair index p (0 SS capture, 1 SS playback, 2 FM, 3 I2S port 1, 4 I2S port 0) takes its right word from slot 2+2p and its left word from slot 3+2p.
- R7: An accepted pair raises bit p of `sub_stb` for exactly one cycle, on the cycle after its left-slot word. At the same time it presents both of its words on its lanes of `sub_right` and `sub_left`.
- R8: With intercept disabled, the pair's slot data is ignored: no strobe is raised and its substituted data outputs keep their earlier values.
- R9: At most one bit of `sub_stb` is high in any cycle.
- R10: Cycles with `slot_stb` low do not affect requests, captured words or outputs, whatever `slot_idx` and `slot_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_stb | input | 1 | A slot word is present this cycle |
| slot_idx | input | 4 | Slot number of the present word (0 to 11) |
| slot_data | input | DW | DSP input word for that slot |
| rate_tick | input | 5 | Per-pair sample-rate tick |
| full_rate | input | 5 | Per-pair flag: pair runs at the frame rate |
| icpt_en | input | 5 | Per-pair intercept enable |
| dsp_vld | input | 5 | Per-pair DSP valid flags from the control slot, sampled at slot 0 |
| sub_stb | output | 5 | Per-pair substitution strobe |
| sub_right | output | 5*DW | Right words, pair p in lane p |
| sub_left | output | 5*DW | Left words, pair p in lane p |
| stat_word | output | 16 | Outgoing status word carrying the request bits |

## Verification
The bench builds the block with the default DW of 16, so every slot word carries a distinct value derived from a per-frame seed. With those values, a strobe on the wrong pair, or swapped right and left lanes, shows up as a data mismatch. Pairs of frames walk the request-then-accept sequence, with the enable, valid and request conditions removed one at a time. Idle gaps filled with misleading slot numbers and data probe R10.

// File: rtl/slot_intercept.sv
module slot_intercept #(
  parameter int DW = 16,
  parameter int SW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_stb,
  input  logic [SW-1:0]    slot_idx,
  input  logic [DW-1:0]    slot_data,
  input  logic [4:0]       rate_tick,
  input  logic [4:0]       full_rate,
  input  logic [4:0]       icpt_en,
  input  logic [4:0]       dsp_vld,
  output logic [4:0]       sub_stb,
  output logic [5*DW-1:0]  sub_right,
  output logic [5*DW-1:0]  sub_left,
  output logic [15:0]      stat_word
);
  localparam int NP = 5;

  logic [NP-1:0] tick_seen, req_q, acc_q;
  wire frm = slot_stb && (slot_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_seen <= '0;
      req_q     <= '0;
      acc_q     <= '0;
    end else if (frm) begin
      tick_seen <= '0;
      req_q     <= full_rate | tick_seen | rate_tick;
      acc_q     <= icpt_en & (full_rate | (req_q & dsp_vld));
    end else begin
      tick_seen <= tick_seen | rate_tick;
    end
  end

  assign stat_word = {1'b0, req_q[0], req_q[1], 1'b0, req_q[3], req_q[4], req_q[2], 9'b0};

  for (genvar p = 0; p < NP; p++) begin : g_pair
    localparam logic [SW-1:0] RS = SW'(2 + 2*p);
    localparam logic [SW-1:0] LS = SW'(3 + 2*p);
    logic [DW-1:0] hold_r, out_r, out_l;
    logic          stb_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_r <= '0;
        out_r  <= '0;
        out_l  <= '0;
        stb_q  <= 1'b0;
      end else begin
        stb_q <= slot_stb && (slot_idx == LS) && acc_q[p];
        if (slot_stb && (slot_idx == RS) && acc_q[p]) hold_r <= slot_data;
        if (slot_stb && (slot_idx == LS) && acc_q[p]) begin
          out_r <= hold_r;
          out_l <= slot_data;
        end
      end
    end

    assign sub_stb[p]             = stb_q;
    assign sub_right[p*DW +: DW]  = out_r;
    assign sub_left[p*DW +: DW]   = out_l;

    AST_STB_AFTER_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      sub_stb[p] |-> $past(slot_stb && slot_idx == LS)); // R7
    AST_FULL_RATE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (frm && full_rate[p]) |=> req_q[p]); // R4
    AST_NO_ACC_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (frm && !icpt_en[p]) |=> !acc_q[p]); // R8
  end

  AST_ONE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sub_stb)); // R9
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frm |=> $stable(stat_word)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |=> ($stable(sub_right) && $stable(sub_left) && sub_stb == '0)); // R10
endmodule

// File: tb/slot_intercept_tb.sv
module slot_intercept_tb;
  localparam int DW = 16;
  logic clk = 0, rst_n = 0;
  logic slot_stb = 0;
  logic [3:0] slot_idx = 0;
  logic [DW-1:0] slot_data = 0;
  logic [4:0] rate_tick = 0, full_rate = 0, icpt_en = 0, dsp_vld = 0;
  logic [4:0] sub_stb;
  logic [5*DW-1:0] sub_right, sub_left;
  logic [15:0] stat_word;
  int n_chk = 0, n_fail = 0;
  int stb_cnt[5];
  logic [DW-1:0] got_r[5], got_l[5];
  logic [15:0] stat_seen;
  logic multi_hot = 0;

  always #2 clk = ~clk;

  slot_intercept #(.DW(DW), .SW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .slot_idx(slot_idx),
    .slot_data(slot_data), .rate_tick(rate_tick), .full_rate(full_rate),
    .icpt_en(icpt_en), .dsp_vld(dsp_vld), .sub_stb(sub_stb),
    .sub_right(sub_right), .sub_left(sub_left), .stat_word(stat_word));

  always @(negedge clk) begin
    if ($countones(sub_stb) > 1) multi_hot = 1;
    for (int p = 0; p < 5; p++)
      if (sub_stb[p]) begin
        stb_cnt[p]++;
        got_r[p] = sub_right[p*DW +: DW];
        got_l[p] = sub_left[p*DW +: DW];
      end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stat_of(input logic [4:0] r);
    return {1'b0, r[0], r[1], 1'b0, r[3], r[4], r[2], 9'b0};
  endfunction

  task automatic frame(input logic [4:0] en, input logic [4:0] vld, input logic [4:0] ticks,
                       input logic [4:0] full, input logic [15:0] seed, input bit gaps);
    @(negedge clk);
    for (int p = 0; p < 5; p++) stb_cnt[p] = 0;
    icpt_en = en; full_rate = full;
    rate_tick = ticks; slot_stb = 0;
    @(negedge clk);
    rate_tick = 0;
    for (int s = 0; s < 12; s++) begin
      slot_stb = 1; slot_idx = 4'(s); slot_data = seed + 16'(s);
      dsp_vld = (s == 0) ? vld : 5'h0;
      @(negedge clk);
      if (s == 1) stat_seen = stat_word;
      if (gaps) begin
        slot_stb = 0; slot_idx = 4'(3 + (s % 8)); slot_data = 16'hDEAD;
        @(negedge clk);
      end
    end
    slot_stb = 0; slot_idx = 0;
    @(negedge clk);
  endtask

  task automatic expect_subs(input string req, input logic [4:0] mask, input logic [15:0] seed);
    for (int p = 0; p < 5; p++) begin
      check(req, stb_cnt[p], mask[p] ? 1 : 0);
      if (mask[p]) begin
        check({req, " right"}, got_r[p], seed + 16'(2 + 2*p));
        check({req, " left"}, got_l[p], seed + 16'(3 + 2*p));
      end
    end
  endtask

  task automatic t_reset();
    check("R1 stb", sub_stb, 0);
    check("R1 stat", stat_word, 0);
    check("R1 right", sub_right[31:0], 0);
  endtask

  task automatic t_request();
    frame(0, 0, 5'b00100, 0, 16'h100, 0);
    check("R2 fm bit9", stat_seen, 16'h0200);
    check("R3 held", stat_word, 16'h0200);
    frame(0, 0, 5'b11011, 0, 16'h100, 0);
    check("R2 others", stat_seen, stat_of(5'b11011));
    frame(0, 0, 0, 0, 16'h100, 0);
    check("R2 cleared", stat_seen, 0);
  endtask

  task automatic t_subst();
    frame(5'h1f, 5'h1f, 5'h1f, 0, 16'h1000, 0);
    expect_subs("R5 no prior req", 0, 16'h1000);
    frame(5'h1f, 5'h1f, 5'h1f, 0, 16'h2000, 0);
    expect_subs("R6 R7 all pairs", 5'h1f, 16'h2000);
  endtask

  task automatic t_disabled();
    frame(5'h1f, 5'h1f, 5'h1f, 0, 16'h3000, 0);
    frame(5'b11011, 5'h1f, 5'h1f, 0, 16'h4000, 0);
    expect_subs("R8 fm disabled", 5'b11011, 16'h4000);
    check("R8 fm data kept", got_l[2], 16'h3007);
    check("R8 fm port kept", sub_left[2*DW +: DW], 16'h3007);
  endtask

  task automatic t_valid();
    frame(5'h1f, 5'h1f, 5'h1f, 0, 16'h5000, 0);
    frame(5'h1f, 5'b01110, 5'h1f, 0, 16'h6000, 0);
    expect_subs("R5 valid low", 5'b01110, 16'h6000);
    frame(5'h1f, 5'h1f, 5'b00001, 0, 16'h7000, 0);
    frame(5'h1f, 5'h1f, 0, 0, 16'h7100, 0);
    expect_subs("R5 req only pair0", 5'b00001, 16'h7100);
  endtask

  task automatic t_full();
    frame(5'b00100, 0, 0, 5'b00100, 16'h8000, 0);
    check("R4 req", stat_seen, 16'h0200);
    expect_subs("R4 accept", 5'b00100, 16'h8000);
  endtask

  task automatic t_gaps();
    frame(5'h1f, 5'h1f, 5'h1f, 0, 16'h9000, 1);
    frame(5'h1f, 5'h1f, 5'h1f, 0, 16'hA000, 1);
    expect_subs("R10 gaps", 5'h1f, 16'hA000);
    check("R9 onehot", multi_hot, 0);
  endtask

  initial begin
    for (int p = 0; p < 5; p++) begin stb_cnt[p] = 0; got_r[p] = 0; got_l[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_request();
    t_subst();
    t_disabled();
    t_valid();
    t_full();
    t_gaps();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule